// File: doc/BRIEF.md
# Programmable Square-Wave Timer Divider

This block divides a system clock enable by a programmable 16-bit value and produces a square-wave level output. Its main use is as a 16x baud clock source for serial channels. To get a 16x clock for a given baud rate, program the divisor as the enable rate divided by 32 times the baud rate. Software loads the divisor as two bytes through a small write port. It then runs the timer with a start strobe and halts it with a stop strobe.

Each half-period of the output lasts exactly the divisor number of input enables. The output frequency is therefore the enable rate divided by twice the divisor. A terminal-count interrupt flag is raised once per full output period and stays set until a stop command. Divisor values 0 and 1 are illegal. The block runs them as 2 and reports them on an error output.

The output is a level meant for use as a clock enable by downstream logic. It is not a gated clock.

Top module: `sqwave_divider`

## Requirements
- R1: After reset, `wave_out` and `tc_irq` are 0, the timer is stopped, and the divisor is 0. While stopped, `wave_out` does not change whatever `tick_en` does.
- R2: A write with `wr_en`=1 stores `wr_data` into the upper divisor byte (bits 15:8) when `wr_hi`=1, and into the lower byte (bits 7:0) when `wr_hi`=0.
- R3: A `start` strobe without `stop` loads the counter from the divisor and sets `wave_out` to 1 on the next clock edge.
- R4: While running, `wave_out` toggles after exactly n cycles with `tick_en`=1, counted from the last start or toggle. Cycles with `tick_en`=0 are not counted.
- R5: `tc_irq` is set in the same cycle that `wave_out` goes from 0 to 1 by counting. It is not set by a start. Once set, it stays 1 until a stop or a reset.
- R6: A `stop` strobe clears `wave_out` and `tc_irq` and halts counting on the next edge. When `start` and `stop` arrive in the same cycle, `stop` wins.
- R7: A divisor of 0 or 1 gives a half-period of 2 enables, and `div_err` is 1 while the stored divisor is below 2.
- R8: A divisor written while the timer runs does not change the current half-period. It takes effect at the next reload, which is a toggle or a start.
- R9: A `start` while running restarts the half-period, holding `wave_out` at 1 for a full n further enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Input clock enable that the divider counts |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_hi | input | 1 | 1 selects the upper byte, 0 the lower byte |
| wr_data | input | 8 | Byte to write |
| start | input | 1 | Start command strobe |
| stop | input | 1 | Stop command strobe, clears the interrupt |
| wave_out | output | 1 | Square-wave output level |
| tc_irq | output | 1 | Terminal-count interrupt flag |
| div_err | output | 1 | Stored divisor is 0 or 1 |

## Verification
The bench measures half-periods in enables across several divisors, including the illegal values 0 and 1, and with sparse enables. A design that counted clocks instead of enables, or that was off by one, would produce a wrong tick count. Interrupt timing is checked after the first and second toggles. A flag raised on the falling edge or on start would show up early. A mid-run divisor write must leave the running half-period alone, so a design that reloads immediately fails. Start/stop collision and restart while running are also exercised. A design that let start win, or that kept the old count on restart, would toggle at the wrong time.

// File: rtl/sqwave_divider.sv
module sqwave_divider #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  input  logic          start,
  input  logic          stop,
  output logic          wave_out,
  output logic          tc_irq,
  output logic          div_err
);
  localparam int W = 2 * BW;

  logic [W-1:0] div_q, cnt_q, eff;
  logic run_q, wave_q, irq_q;

  assign div_err  = (div_q < W'(2));
  assign eff      = div_err ? W'(2) : div_q;
  assign wave_out = wave_q;
  assign tc_irq   = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_hi) div_q[W-1:BW] <= wr_data;
        else       div_q[BW-1:0] <= wr_data;
      end
      if (stop) begin
        run_q  <= 1'b0;
        wave_q <= 1'b0;
        irq_q  <= 1'b0;
        cnt_q  <= '0;
      end else if (start) begin
        run_q  <= 1'b1;
        wave_q <= 1'b1;
        cnt_q  <= eff;
      end else if (run_q && tick_en) begin
        if (cnt_q <= W'(1)) begin
          cnt_q  <= eff;
          wave_q <= ~wave_q;
          if (!wave_q) irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sqwave_divider_chk.sv
module sqwave_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic start,
  input logic stop,
  input logic wave_out,
  input logic tc_irq
);
  a_r4_no_tick_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !start && !stop) |=> $stable(wave_out));
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!wave_out && !tc_irq));
  a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> wave_out);
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_irq && !stop) |=> tc_irq);
  a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_irq) |-> $rose(wave_out));
endmodule

bind sqwave_divider sqwave_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start), .stop(stop),
  .wave_out(wave_out), .tc_irq(tc_irq)
);

// File: tb/sqwave_divider_tb.sv
module sqwave_divider_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, wr_hi = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [7:0] wr_data = '0;
  logic wave_out, tc_irq, div_err;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sqwave_divider u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .start(start), .stop(stop), .wave_out(wave_out),
    .tc_irq(tc_irq), .div_err(div_err)
  );

  // {divisor[15:0], gap[1:0]}: an enable every gap+1 cycles
  localparam logic [17:0] VEC [8] = '{
    {16'd2, 2'd0}, {16'd3, 2'd0}, {16'd5, 2'd1}, {16'd0, 2'd0},
    {16'd1, 2'd2}, {16'd256, 2'd0}, {16'd4660, 2'd0}, {16'd7, 2'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; start = 0; stop = 0; tick_en = 0;
  endtask

  task automatic wr_div(input logic [15:0] n);
    wr_en = 1; wr_hi = 0; wr_data = n[7:0]; cyc();
    wr_en = 1; wr_hi = 1; wr_data = n[15:8]; cyc();
  endtask

  task automatic measure(input int gap, output int ticks);
    logic prev;
    int phase;
    prev = wave_out; ticks = 0; phase = 0;
    for (int i = 0; i < 40000; i++) begin
      tick_en = (phase == gap);
      if (tick_en) ticks++;
      phase = (phase == gap) ? 0 : phase + 1;
      cyc();
      if (wave_out != prev) return;
    end
    ticks = -1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t;
    logic [15:0] n;
    int neff;
    @(negedge clk); cyc(); cyc();
    rst_n = 1; cyc();
    chk("R1 wave after reset", wave_out, 0);
    chk("R1 irq after reset", tc_irq, 0);
    chk("R1 div_err for zero divisor", div_err, 1);
    for (int i = 0; i < 6; i++) begin tick_en = 1; cyc(); end
    chk("R1 stopped timer holds output", wave_out, 0);

    foreach (VEC[k]) begin
      n = VEC[k][17:2];
      neff = (n < 2) ? 2 : int'(n);
      wr_div(n);
      chk("R2/R7 div_err", div_err, (n < 2) ? 1 : 0);
      start = 1; cyc();
      chk("R3 start drives wave high", wave_out, 1);
      measure(int'(VEC[k][1:0]), t);
      chk("R4/R7 first half-period", t, neff);
      chk("R5 no irq on falling toggle", tc_irq, 0);
      measure(int'(VEC[k][1:0]), t);
      chk("R4 second half-period", t, neff);
      chk("R5 irq on rising toggle", tc_irq, 1);
      for (int i = 0; i < 3; i++) cyc();
      chk("R5 irq held", tc_irq, 1);
      stop = 1; cyc();
      chk("R6 stop clears irq", tc_irq, 0);
      chk("R6 stop clears wave", wave_out, 0);
    end

    // R8: mid-run write affects only the next reload
    wr_div(16'd4);
    start = 1; cyc();
    tick_en = 1; cyc();
    wr_div(16'd6);
    measure(0, t);
    chk("R8 current half keeps old divisor", t, 3);
    measure(0, t);
    chk("R8 new divisor at reload", t, 6);
    stop = 1; cyc();

    // R9: restart while running
    wr_div(16'd5);
    start = 1; cyc();
    tick_en = 1; cyc(); tick_en = 1; cyc(); tick_en = 1; cyc();
    start = 1; cyc();
    chk("R9 restart keeps wave high", wave_out, 1);
    measure(0, t);
    chk("R9 restart gives full half-period", t, 5);
    stop = 1; cyc();

    // R6: stop wins over simultaneous start
    start = 1; stop = 1; cyc();
    chk("R6 stop beats start", wave_out, 0);
    for (int i = 0; i < 12; i++) begin tick_en = 1; cyc(); end
    chk("R6 halted after collision", wave_out, 0);

    // R2: upper byte lands in bits 15:8 (0x0100 = 256)
    wr_en = 1; wr_hi = 0; wr_data = 8'h00; cyc();
    chk("R2 zero divisor flagged", div_err, 1);
    wr_en = 1; wr_hi = 1; wr_data = 8'h01; cyc();
    chk("R2 upper byte write", div_err, 0);
    start = 1; cyc();
    measure(0, t);
    chk("R2 upper byte weight", t, 256);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule